// File: doc/BRIEF.md
# Shared-Multiple Transposed FIR Filter

A four-tap FIR filter for unsigned integer samples, built in transposed direct form. Each accepted sample is scaled by all four programmable coefficients in the same cycle, and the products are folded into a chain of partial-sum registers. The output register holds the filtered value Y(n).

No tap has a multiplier of its own. One precomputer per filter forms six small multiples of the incoming sample: 1x, 2x, 3x, 4x, 8x and 12x. Every tap builds its product from these six values. Each coefficient is split into 4-bit groups. In each group, the low bit pair picks one of {0, 1x, 2x, 3x} and the high bit pair picks one of {0, 4x, 8x, 12x}. The two picks are added, and the group sums are combined with 4-bit shifts between them.

Software or a controller loads coefficients one tap at a time through a write strobe, a tap index and a value. Samples arrive with a valid strobe. Each accepted sample yields one output, marked by its own valid strobe, in the following cycle.

Top module: `fir_share_top`

## Requirements
- R1: While rst_ni is low, y_o reads 0, y_valid_o is low and every partial sum is cleared. The first result after reset therefore depends only on samples taken after reset.
- R2: y_valid_o is high in the cycle after a clock edge that accepted sample_valid_i high, and low otherwise.
- R3: The output for accepted sample n is Y(n) = C0·x(n) + C1·x(n−1) + C2·x(n−2) + C3·x(n−3). Only accepted samples are counted, and samples before reset count as zero. Each C_i is the value tap i held when sample n−i was accepted. The result appears on y_o one cycle after acceptance.
- R4: y_o is as wide as the product plus two guard bits, 18 bits by default. Full-scale samples with all coefficients at full scale give the exact value 4·255·255 = 260100.
- R5: In a cycle without sample_valid_i, y_o and all partial sums keep their values.
- R6: A pulse on coef_we_i stores coef_val_i into tap coef_idx_i. Index 0 is the tap that scales the newest sample, and index 3 the oldest. The new value applies to samples accepted from the next cycle on. A sample accepted in the same cycle as the write uses the old value.
- R7: Each tap product equals x·C exactly for every coefficient value, including 0. It is formed only from selections out of {0,1,2,3}·x and {0,4,8,12}·x, driven by 2-bit coefficient groups.
- R8: Reset sets all four coefficients to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W (8) | Input sample, unsigned |
| sample_valid_i | input | 1 | Sample strobe |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_idx_i | input | $clog2(TAPS) (2) | Tap to write |
| coef_val_i | input | COEF_W (8) | Coefficient value, unsigned |
| y_o | output | DATA_W+COEF_W+2 (18) | Filter output |
| y_valid_o | output | 1 | Output strobe |

## Verification
The bench uses the default parameters: 8-bit samples, 8-bit coefficients and four taps. With these values each coefficient has two 4-bit groups, so all 256 coefficient values can be swept through one tap at a random sample. A full-scale run fills the two guard bits close to their limit.

A scoreboard drives mixed streams against a convolution model that snapshots the coefficients per sample. The streams include an impulse, random data with idle gaps, writes that coincide with samples, and a reset in the middle of a stream.

// File: rtl/fir_share_pkg.sv
package fir_share_pkg;
  // Order of the shared multiples on the precomputer bus
  localparam int unsigned ALPHA_CNT = 6;
  localparam int unsigned IX_1  = 0;
  localparam int unsigned IX_2  = 1;
  localparam int unsigned IX_3  = 2;
  localparam int unsigned IX_4  = 3;
  localparam int unsigned IX_8  = 4;
  localparam int unsigned IX_12 = 5;
  // 12x needs four extra bits above the sample
  localparam int unsigned ALPHA_EXT = 4;
  localparam int unsigned GROUP_W   = 4;
endpackage

// File: rtl/fir_share_precomp.sv
module fir_share_precomp
  import fir_share_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = DATA_W + ALPHA_EXT
) (
  input  logic [DATA_W-1:0]                 x_i,
  output logic [ALPHA_CNT-1:0][AW-1:0]      alpha_o
);
  logic [AW-1:0] m1, m2, m4, m8;

  assign m1 = AW'(x_i);
  assign m2 = m1 << 1;
  assign m4 = m1 << 2;
  assign m8 = m1 << 3;

  // Only two adders for the whole filter
  always_comb begin
    alpha_o        = '0;
    alpha_o[IX_1]  = m1;
    alpha_o[IX_2]  = m2;
    alpha_o[IX_3]  = m2 + m1;
    alpha_o[IX_4]  = m4;
    alpha_o[IX_8]  = m8;
    alpha_o[IX_12] = m8 + m4;
  end
endmodule

// File: rtl/fir_share_coef_bank.sv
module fir_share_coef_bank #(
  parameter int unsigned TAPS   = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned IDX_W = $clog2(TAPS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [COEF_W-1:0]            val_i,
  output logic [TAPS-1:0][COEF_W-1:0]  coef_o
);
  logic [TAPS-1:0][COEF_W-1:0] coef_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
    end else if (we_i && (32'(idx_i) < TAPS)) begin
      coef_q[idx_i] <= val_i;
    end
  end

  assign coef_o = coef_q;

  p_coef_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> coef_q[$past(idx_i)] == $past(val_i));
endmodule

// File: rtl/fir_share_tap.sv
module fir_share_tap
  import fir_share_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned AW     = DATA_W + ALPHA_EXT,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned NGRP   = COEF_W / GROUP_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ALPHA_CNT-1:0][AW-1:0]    alpha_i,
  input  logic [COEF_W-1:0]               coef_i,
  output logic [PROD_W-1:0]               prod_o
);
  logic [NGRP:0][PROD_W-1:0] part;
  logic [NGRP-1:0][AW-1:0]   grp_sum;

  assign part[0] = '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [AW-1:0] lo_sel, hi_sel;

    always_comb begin
      unique case (coef_i[GROUP_W*g +: 2])
        2'd0:    lo_sel = '0;
        2'd1:    lo_sel = alpha_i[IX_1];
        2'd2:    lo_sel = alpha_i[IX_2];
        default: lo_sel = alpha_i[IX_3];
      endcase
      unique case (coef_i[GROUP_W*g+2 +: 2])
        2'd0:    hi_sel = '0;
        2'd1:    hi_sel = alpha_i[IX_4];
        2'd2:    hi_sel = alpha_i[IX_8];
        default: hi_sel = alpha_i[IX_12];
      endcase
    end

    // at most 15x, fits in AW
    assign grp_sum[g]  = lo_sel + hi_sel;
    assign part[g+1]   = part[g] + (PROD_W'(grp_sum[g]) << (GROUP_W*g));
  end

  assign prod_o = part[NGRP];

  p_prod_exact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_o == PROD_W'(alpha_i[IX_1]) * PROD_W'(coef_i));
  p_zero_coef_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_i == '0) |-> (prod_o == '0));
endmodule

// File: rtl/fir_share_top.sv
module fir_share_top
  import fir_share_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned TAPS   = 4,
  localparam int unsigned AW     = DATA_W + ALPHA_EXT,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned ACC_W  = PROD_W + $clog2(TAPS),
  localparam int unsigned IDX_W  = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  input  logic              coef_we_i,
  input  logic [IDX_W-1:0]  coef_idx_i,
  input  logic [COEF_W-1:0] coef_val_i,
  output logic [ACC_W-1:0]  y_o,
  output logic              y_valid_o
);
  localparam longint unsigned MAX_SUM =
    longint'(TAPS) * ((longint'(1) << DATA_W) - 1) * ((longint'(1) << COEF_W) - 1);

  logic [ALPHA_CNT-1:0][AW-1:0]  alpha;
  logic [TAPS-1:0][COEF_W-1:0]   coef;
  logic [TAPS-1:0][PROD_W-1:0]   prod;
  // psum_q[k] carries the pending sum for tap k+1 onward
  logic [TAPS-2:0][ACC_W-1:0]    psum_q, psum_d;
  logic [ACC_W-1:0]              y_d;

  fir_share_precomp #(.DATA_W(DATA_W)) u_pre (
    .x_i     (sample_i),
    .alpha_o (alpha)
  );

  fir_share_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_we_i),
    .idx_i  (coef_idx_i),
    .val_i  (coef_val_i),
    .coef_o (coef)
  );

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    fir_share_tap #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_tap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alpha_i (alpha),
      .coef_i  (coef[t]),
      .prod_o  (prod[t])
    );
  end

  for (genvar k = 0; k < TAPS-1; k++) begin : g_chain
    if (k == TAPS-2) begin : g_last
      assign psum_d[k] = ACC_W'(prod[k+1]);
    end else begin : g_mid
      assign psum_d[k] = ACC_W'(prod[k+1]) + psum_q[k+1];
    end
  end

  assign y_d = ACC_W'(prod[0]) + psum_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_q    <= '0;
      y_o       <= '0;
      y_valid_o <= 1'b0;
    end else begin
      y_valid_o <= sample_valid_i;
      if (sample_valid_i) begin
        psum_q <= psum_d;
        y_o    <= y_d;
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> $past(sample_valid_i));
  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_valid_i) |-> ($stable(y_o) && $stable(psum_q)));
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> (longint'(y_o) <= MAX_SUM));
endmodule

// File: tb/sim_fir_share_top.sv
`timescale 1ns/1ps
module sim_fir_share_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sample_i = '0;
  logic        sample_valid_i = 1'b0;
  logic        coef_we_i = 1'b0;
  logic [1:0]  coef_idx_i = '0;
  logic [7:0]  coef_val_i = '0;
  logic [17:0] y_o;
  logic        y_valid_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  longint unsigned hx[4];
  longint unsigned hc[4][4];
  longint unsigned cm[4];
  longint unsigned exp_q[$];
  string           tag_q[$];

  always #2 clk = ~clk;

  fir_share_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample_i), .sample_valid_i(sample_valid_i),
    .coef_we_i(coef_we_i), .coef_idx_i(coef_idx_i), .coef_val_i(coef_val_i),
    .y_o(y_o), .y_valid_o(y_valid_o)
  );

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, expv, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      hx[i] = 0; cm[i] = 0;
      for (int j = 0; j < 4; j++) hc[i][j] = 0;
    end
  endtask

  // Drive one sample, optionally with a coefficient write in the same cycle
  task automatic drive(input logic [7:0] x, input bit wr, input int idx, input int val,
                       input string tag);
    longint unsigned e = 0;
    @(negedge clk);
    sample_i = x; sample_valid_i = 1'b1;
    coef_we_i = wr; coef_idx_i = 2'(idx); coef_val_i = 8'(val);
    for (int i = 3; i > 0; i--) begin
      hx[i] = hx[i-1];
      for (int j = 0; j < 4; j++) hc[i][j] = hc[i-1][j];
    end
    hx[0] = x;
    for (int j = 0; j < 4; j++) hc[0][j] = cm[j];
    for (int i = 0; i < 4; i++) e += hc[i][i] * hx[i];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (wr) cm[idx] = longint'(val);
  endtask

  task automatic wcoef(input int idx, input int val);
    @(negedge clk);
    sample_valid_i = 1'b0;
    coef_we_i = 1'b1; coef_idx_i = 2'(idx); coef_val_i = 8'(val);
    cm[idx] = longint'(val);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_valid_i = 1'b0; coef_we_i = 1'b0;
    end
  endtask

  // Monitor: scoreboard pop and valid timing
  always @(posedge clk) begin
    bit pv;
    pv = sample_valid_i && rst_n;
    #1;
    if (rst_n && !done) begin
      if (pv || y_valid_o) check(y_valid_o == pv, "R2", longint'(y_valid_o), longint'(pv));
      if (y_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 (no result expected)", longint'(y_o), 0);
        end else begin
          longint unsigned e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(longint'(y_o) == e, t, longint'(y_o), e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(y_o == '0 && !y_valid_o, "R1", longint'(y_o), 0);
    rst_n = 1'b1;
    idle(2);

    // R8: coefficients zero after reset -> output zero
    drive(8'd200, 0, 0, 0, "R8");
    idle(2);

    // R3: impulse response with random coefficients
    for (int i = 0; i < 4; i++) wcoef(i, int'($urandom_range(1, 255)));
    idle(1);
    drive(8'd1, 0, 0, 0, "R3 impulse");
    for (int i = 0; i < 4; i++) drive(8'd0, 0, 0, 0, "R3 impulse");
    idle(2);

    // R3/R5: random stream with idle gaps
    for (int i = 0; i < 4; i++) wcoef(i, int'($urandom_range(0, 255)));
    for (int n = 0; n < 60; n++) begin
      drive(8'($urandom_range(0, 255)), 0, 0, 0, "R3 stream");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(2);

    // R5: hold while idle
    @(negedge clk);
    held = y_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(y_o == held, "R5 hold", longint'(y_o), longint'(held));
    end
    // Next output confirms partial sums were untouched by idle cycles
    drive(8'd0, 0, 0, 0, "R5 state");
    idle(2);

    // R4: full scale
    for (int i = 0; i < 4; i++) wcoef(i, 255);
    for (int n = 0; n < 6; n++) drive(8'd255, 0, 0, 0, "R4 full scale");
    idle(2);

    // R6: write coincident with sample uses old coefficient
    for (int i = 0; i < 4; i++) wcoef(i, 3 + i);
    drive(8'd10, 1, 0, 100, "R6 same-cycle");
    drive(8'd20, 1, 3, 50, "R6 next sample");
    drive(8'd30, 0, 0, 0, "R6 tap order");
    drive(8'd40, 0, 0, 0, "R6 tap order");
    drive(8'd50, 0, 0, 0, "R6 tap order");
    idle(2);

    // R7: every coefficient value on tap 0
    for (int i = 1; i < 4; i++) wcoef(i, 0);
    for (int c = 0; c < 256; c++) begin
      wcoef(0, c);
      drive(8'($urandom_range(0, 255)), 0, 0, 0, "R7 sweep");
    end
    drive(8'hFF, 1, 0, 255, "R7 sweep");
    drive(8'hFF, 0, 0, 0, "R7 sweep");
    idle(2);

    // R1: reset in the middle of a stream
    for (int i = 0; i < 4; i++) wcoef(i, int'($urandom_range(1, 255)));
    for (int n = 0; n < 5; n++) drive(8'($urandom_range(1, 255)), 0, 0, 0, "R3 pre-reset");
    idle(1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(y_o == '0 && !y_valid_o, "R1 mid reset", longint'(y_o), 0);
    model_clear();
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(8'd77, 0, 0, 0, "R8 after reset");
    for (int i = 0; i < 4; i++) wcoef(i, i + 1);
    for (int n = 0; n < 5; n++) drive(8'(9 + n), 0, 0, 0, "R1 fresh history");
    idle(3);

    check(exp_q.size() == 0, "R2 drained", longint'(exp_q.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule